// File: doc/BRIEF.md
# Multi-rate TDM serial frame receiver

This block takes one time-division-multiplexed serial line and turns it into a stream of channel bytes. The line runs at one of three data rates (2.048, 4.096 or 8.192 Mb/s), chosen by a static rate select. Every frame lasts 125 microseconds. The number of 8-bit channels in a frame therefore scales with the rate: 32, 64 or 128. Each data bit lasts two periods of the line clock. The block's `clk` port is driven by the inverted line clock, so each rising edge of `clk` marks a falling edge of the line clock. A frame boundary is a `clk` edge at which the active-low frame pulse is sampled low.

A free-running phase counter counts clock periods within the frame. It finds each bit and channel, and a shift register collects the bits, most significant bit first. When a channel's last bit arrives, the block presents the byte for one cycle with its channel number. It pulses `frame_start` at each boundary it accepts, and it reports lock once boundaries have agreed for two frames in a row.

Setting both the qualification enable and the qualification mode inputs turns on jitter-tolerant framing. In that mode a frame pulse within one clock of the predicted boundary is taken as a boundary without disturbing the counter. A pulse anywhere else is ignored, until three such pulses in a row force a realignment.

Top module: `tdm_frame_rx`

## Requirements
- R1: After reset, `byte_valid`, `frame_start` and `locked` are low. Qualification is active only while `qual_en` and `qual_mode` are both high. With only one of them high, every frame pulse realigns as in R2.
- R2: With qualification inactive, a `clk` edge that samples `frame_n` low is a boundary. The next cycle is phase 0 of a new frame (channel 0, bit 7), and `frame_start` is high for that one cycle.
- R3: `rate_sel` 0 gives 32 channels, 1 gives 64, and 2 or 3 gives 128. Each channel spans 16 clock periods (2 per bit). Without a frame pulse, the counter wraps on its own after the last channel.
- R4: The bit on `ser_in` is sampled at the edge that ends the second period of that bit. The first bit of a channel is bit 7 of `byte_data`, and the last is bit 0.
- R5: `byte_valid` is high for exactly one cycle, the cycle after the edge that samples a channel's bit 0. `byte_chan` holds that channel's index (0 to channels-1), which restarts at 0 after the last channel.
- R6: With qualification active, a pulse sampled at phase last-1, last or 0 is accepted. `frame_start` pulses, and the phase counter continues unchanged, so the bytes stay aligned.
- R7: With qualification active, a pulse outside that window is ignored: there is no `frame_start` and the counter keeps running. The third such pulse in a row realigns as in R2. Any accepted pulse restarts the count of misses.
- R8: An accepted pulse inside the window raises an agreement count, and `locked` is high once the count reaches 2. Two things clear the count and drop `locked` in the next cycle: a pulse that realigns from outside the window, and an ignored stray pulse.
- R9: A change of `rate_sel` clears the phase counter, the shift register and the agreement count. `locked` is low in the next cycle. The first `byte_valid` (channel 0) comes in the 17th cycle after the edge that sees the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Inverted line clock; each rising edge is a line-clock falling edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial TDM data |
| frame_n | input | 1 | Active-low frame pulse |
| rate_sel | input | 2 | Data rate: 0 = 2.048, 1 = 4.096, 2/3 = 8.192 Mb/s |
| qual_en | input | 1 | Boundary qualification enable |
| qual_mode | input | 1 | Boundary qualification mode; both must be high |
| byte_data | output | 8 | Assembled channel byte |
| byte_chan | output | 7 | Channel index of `byte_data` |
| byte_valid | output | 1 | One-cycle strobe for a new byte |
| frame_start | output | 1 | One-cycle pulse at each accepted boundary |
| locked | output | 1 | Boundaries have agreed for two frames |

## Verification
The strobe for a frame's last channel and the `frame_start` of the next boundary are both driven from the same clock edge, so on an aligned stream they always share a cycle. The bench drives frames at all three rates with a byte pattern that depends on the channel. In the shared cycle it checks the strobe first (it must carry the top channel index and the right byte) and then treats the boundary as the restart of its expected channel sequence. Early, late and stray pulses under qualification test the same coincidence: the last-channel strobe must still arrive with the correct index while the boundary pulse moves by one cycle or disappears.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

    localparam int BASE_CHANS  = 32;
    localparam int RATE_STEPS  = 3;
    localparam int BITS_PER_CH = 8;
    localparam int CLK_PER_BIT = 2;
    localparam int MISS_LIMIT  = 3;
    localparam int AGREE_NEED  = 2;

    localparam int MAX_CHANS  = BASE_CHANS << (RATE_STEPS - 1);
    localparam int CH_W       = $clog2(MAX_CHANS);
    localparam int CLK_PER_CH = BITS_PER_CH * CLK_PER_BIT;
    localparam int SLOT_W     = $clog2(CLK_PER_CH);
    localparam int POS_W      = CH_W + SLOT_W;

    typedef enum logic [1:0] {
        RATE_LOW      = 2'd0,
        RATE_MID      = 2'd1,
        RATE_HIGH     = 2'd2,
        RATE_HIGH_ALT = 2'd3
    } rate_e;

    typedef struct packed {
        logic [BITS_PER_CH-1:0] data;
        logic [CH_W-1:0]        chan;
        logic                   valid;
    } rx_byte_t;

    // Phase value of the final clock period of a frame at the given rate.
    function automatic logic [POS_W-1:0] frame_last(rate_e r);
        int steps;
        steps = int'(r);
        if (steps > RATE_STEPS - 1) steps = RATE_STEPS - 1;
        return POS_W'((BASE_CHANS << steps) * CLK_PER_CH - 1);
    endfunction

endpackage

// File: rtl/tdm_rx_timing.sv
module tdm_rx_timing
    import tdm_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_n,
    input  logic             qual_on,
    input  rate_e            rate,
    output logic [POS_W-1:0] pos,
    output logic             rate_clear,
    output logic             frame_start,
    output logic             locked
);

    localparam int MISS_W  = $clog2(MISS_LIMIT + 1);
    localparam int AGREE_W = $clog2(AGREE_NEED + 1);

    rate_e              rate_q;
    logic [POS_W-1:0]   pos_q;
    logic [POS_W-1:0]   last_p;
    logic [MISS_W-1:0]  miss_q;
    logic [AGREE_W-1:0] agree_q;
    logic               fs_q;

    logic pulse, at_last, in_win, strike_out;
    logic accept, realign, stray, rate_chg;

    always_comb begin
        rate_chg   = (rate != rate_q);
        last_p     = frame_last(rate_q);
        pulse      = !frame_n;
        at_last    = (pos_q == last_p);
        in_win     = at_last || (pos_q == last_p - 1'b1) || (pos_q == '0);
        strike_out = (miss_q == MISS_W'(MISS_LIMIT - 1));
        accept     = pulse && (!qual_on || in_win || strike_out);
        realign    = accept && (!qual_on || !in_win);
        stray      = pulse && !accept;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q  <= rate;
            pos_q   <= '0;
            miss_q  <= '0;
            agree_q <= '0;
            fs_q    <= 1'b0;
        end else begin
            rate_q <= rate;
            fs_q   <= accept && !rate_chg;
            if (rate_chg) begin
                pos_q   <= '0;
                miss_q  <= '0;
                agree_q <= '0;
            end else begin
                pos_q <= (realign || at_last) ? '0 : pos_q + 1'b1;

                if (qual_on && pulse && !in_win)
                    miss_q <= strike_out ? '0 : miss_q + 1'b1;
                else if (accept)
                    miss_q <= '0;

                if (accept) begin
                    if (!in_win)
                        agree_q <= '0;
                    else if (agree_q != AGREE_W'(AGREE_NEED))
                        agree_q <= agree_q + 1'b1;
                end else if (stray) begin
                    agree_q <= '0;
                end
            end
        end
    end

    assign pos         = pos_q;
    assign rate_clear  = rate_chg;
    assign frame_start = fs_q;
    assign locked      = (agree_q == AGREE_W'(AGREE_NEED));

    a_r3_pos_in_frame: assert property (@(posedge clk) disable iff (rst)
        pos_q <= last_p);

    a_r2_pulse_realigns: assert property (@(posedge clk) disable iff (rst)
        (!qual_on && pulse && !rate_chg) |=> (pos_q == '0 && frame_start));

    a_r7_stray_keeps_count: assert property (@(posedge clk) disable iff (rst)
        (qual_on && pulse && !in_win && !strike_out && !rate_chg)
        |=> (!frame_start && pos_q == $past(pos_q) + 1'b1));

    a_r8_lock_at_boundary: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> frame_start);

    a_r9_rate_clears: assert property (@(posedge clk) disable iff (rst)
        rate_chg |=> (!locked && pos_q == '0));

endmodule

// File: rtl/tdm_rx_shifter.sv
module tdm_rx_shifter
    import tdm_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [POS_W-1:0] pos,
    input  logic             ser_in,
    output rx_byte_t         rx_out
);

    logic [SLOT_W-1:0]      slot;
    logic                   sample;
    logic                   done;
    logic [BITS_PER_CH-2:0] sr_q;
    rx_byte_t               out_q;

    always_comb begin
        slot   = pos[SLOT_W-1:0];
        sample = (int'(slot) % CLK_PER_BIT) == CLK_PER_BIT - 1;
        done   = int'(slot) == CLK_PER_CH - 1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= '0;
            out_q <= '0;
        end else begin
            out_q.valid <= done && !clear;
            if (clear)
                sr_q <= '0;
            else if (sample)
                sr_q <= {sr_q[BITS_PER_CH-3:0], ser_in};
            if (done && !clear) begin
                out_q.data <= {sr_q, ser_in};
                out_q.chan <= pos[POS_W-1:SLOT_W];
            end
        end
    end

    assign rx_out = out_q;

    a_r5_single_strobe: assert property (@(posedge clk) disable iff (rst)
        out_q.valid |=> !out_q.valid);

    a_r9_no_strobe_on_clear: assert property (@(posedge clk) disable iff (rst)
        clear |=> !out_q.valid);

endmodule

// File: rtl/tdm_frame_rx.sv
module tdm_frame_rx
    import tdm_rx_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ser_in,
    input  logic                   frame_n,
    input  logic [1:0]             rate_sel,
    input  logic                   qual_en,
    input  logic                   qual_mode,
    output logic [BITS_PER_CH-1:0] byte_data,
    output logic [CH_W-1:0]        byte_chan,
    output logic                   byte_valid,
    output logic                   frame_start,
    output logic                   locked
);

    logic [POS_W-1:0] pos;
    logic             rate_clear;
    logic             qual_on;
    rx_byte_t         rx_byte;

    assign qual_on = qual_en & qual_mode;

    tdm_rx_timing timing_i (
        .clk         (clk),
        .rst         (rst),
        .frame_n     (frame_n),
        .qual_on     (qual_on),
        .rate        (rate_e'(rate_sel)),
        .pos         (pos),
        .rate_clear  (rate_clear),
        .frame_start (frame_start),
        .locked      (locked)
    );

    tdm_rx_shifter shifter_i (
        .clk    (clk),
        .rst    (rst),
        .clear  (rate_clear),
        .pos    (pos),
        .ser_in (ser_in),
        .rx_out (rx_byte)
    );

    assign byte_data  = rx_byte.data;
    assign byte_chan  = rx_byte.chan;
    assign byte_valid = rx_byte.valid;

    a_r1_quiet_reset: assert property (@(posedge clk)
        $past(rst) |-> (!byte_valid && !frame_start && !locked));

endmodule

// File: tb/tdm_frame_rx_tb.sv
module tdm_frame_rx_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_in = 1'b0;
    logic       frame_n = 1'b1;
    logic [1:0] rate_sel = 2'd0;
    logic       qual_en = 1'b0;
    logic       qual_mode = 1'b0;
    logic [7:0] byte_data;
    logic [6:0] byte_chan;
    logic       byte_valid;
    logic       frame_start;
    logic       locked;

    int total = 0;
    int bad = 0;
    int nch = 32;
    int flen = 512;
    int seed = 0;
    int exp_chan = 0;
    int fs_cnt = 0;
    int nval = 0;
    bit armed = 1'b0;
    bit resync = 1'b1;

    always #5 clk = ~clk;

    tdm_frame_rx dut_i (
        .clk         (clk),
        .rst         (rst),
        .ser_in      (ser_in),
        .frame_n     (frame_n),
        .rate_sel    (rate_sel),
        .qual_en     (qual_en),
        .qual_mode   (qual_mode),
        .byte_data   (byte_data),
        .byte_chan   (byte_chan),
        .byte_valid  (byte_valid),
        .frame_start (frame_start),
        .locked      (locked)
    );

    function automatic logic [7:0] pat(int ch, int s);
        return 8'((ch * 53 + s) & 255);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_rate(int r);
        rate_sel = 2'(r);
        nch      = 32 << ((r > 2) ? 2 : r);
        flen     = nch * 16;
    endtask

    task automatic do_reset();
        rst     = 1'b1;
        frame_n = 1'b1;
        repeat (3) @(negedge clk);
        rst    = 1'b0;
        armed  = 1'b0;
        fs_cnt = 0;
        nval   = 0;
    endtask

    // Drives len clock periods of stream; frame pulse low in period pulse_at.
    task automatic run_frame(int len, int pulse_at, int probe_p, bit probe_exp);
        logic [7:0] b;
        for (int p = 0; p < len; p++) begin
            @(negedge clk);
            b       = pat(p >> 4, seed);
            frame_n = (p == pulse_at) ? 1'b0 : 1'b1;
            ser_in  = b[3'(7 - ((p >> 1) & 7))];
            if (p == probe_p)
                chk(locked == probe_exp, "R8 lock state", int'(locked), int'(probe_exp));
        end
    endtask

    // Output monitor: strobe is judged before a coincident boundary.
    always @(negedge clk) begin
        if (!rst) begin
            if (byte_valid && armed) begin
                chk(int'(byte_chan) == exp_chan, "R5 channel index", int'(byte_chan), exp_chan);
                chk(byte_data == pat(int'(byte_chan), seed), "R4 byte value",
                    int'(byte_data), int'(pat(int'(byte_chan), seed)));
                exp_chan = (exp_chan + 1) % nch;
                nval++;
            end
            if (frame_start) begin
                fs_cnt++;
                if (!armed || resync) begin
                    armed    = 1'b1;
                    exp_chan = 0;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seen;
        set_rate(0);
        do_reset();
        chk(byte_valid == 1'b0, "R1 valid after reset", int'(byte_valid), 0);
        chk(frame_start == 1'b0, "R1 frame_start after reset", int'(frame_start), 0);
        chk(locked == 1'b0, "R1 locked after reset", int'(locked), 0);

        // Free framing at every rate, then an out-of-window realignment.
        for (int r = 0; r < 3; r++) begin
            set_rate(r);
            seed   = r * 7 + 3;
            resync = 1'b1;
            do_reset();
            run_frame(1, 0, -1, 1'b0);
            repeat (3) run_frame(flen, flen - 1, -1, 1'b0);
            chk(locked == 1'b1, "R8 locked after agreeing frames", int'(locked), 1);
            chk(fs_cnt == 3, "R2 frame_start per pulse", fs_cnt, 3);
            chk(nval == 3 * nch - 1, "R3 strobes per frame", nval, 3 * nch - 1);
            run_frame(flen / 2, flen / 2 - 1, -1, 1'b0);
            run_frame(flen, flen - 1, 2, 1'b0);
            run_frame(flen, flen - 1, 2, 1'b0);
            run_frame(flen, flen - 1, 2, 1'b1);
            chk(fs_cnt == 7, "R2 realign on short frame", fs_cnt, 7);
        end

        // Rate change while locked.
        @(negedge clk);
        frame_n = 1'b1;
        @(negedge clk);
        armed = 1'b0;
        set_rate(1);
        seen = 0;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            if (k == 0) chk(locked == 1'b0, "R9 lock dropped", int'(locked), 0);
            if (byte_valid) seen++;
        end
        chk(seen == 0, "R9 no strobe before first channel", seen, 0);
        @(negedge clk);
        chk(byte_valid == 1'b1, "R9 first strobe timing", int'(byte_valid), 1);
        chk(byte_chan == 7'd0, "R9 counters cleared", int'(byte_chan), 0);

        // Only one qualification bit set: behaves as free framing.
        set_rate(0);
        qual_en   = 1'b1;
        qual_mode = 1'b0;
        seed      = 11;
        resync    = 1'b1;
        do_reset();
        run_frame(100, -1, -1, 1'b0);
        run_frame(flen, flen - 1, -1, 1'b0);
        run_frame(20, -1, -1, 1'b0);
        chk(fs_cnt == 1, "R1 single bit leaves qualification off", fs_cnt, 1);

        // Qualification fully on.
        qual_mode = 1'b1;
        resync    = 1'b0;
        do_reset();
        run_frame(100, -1, -1, 1'b0);
        run_frame(flen, flen - 1, -1, 1'b0);
        run_frame(flen, flen - 1, -1, 1'b0);
        chk(fs_cnt == 0, "R7 stray pulses ignored", fs_cnt, 0);
        run_frame(flen, flen - 1, -1, 1'b0);
        run_frame(flen, flen - 1, 2, 1'b0);
        chk(fs_cnt == 1, "R7 third stray realigns", fs_cnt, 1);
        run_frame(flen, flen - 1, -1, 1'b0);
        run_frame(flen, flen - 2, 2, 1'b1);
        run_frame(flen, -1, -1, 1'b0);
        run_frame(flen, 0, -1, 1'b0);
        run_frame(flen, 200, -1, 1'b0);
        run_frame(flen, flen - 1, 2, 1'b0);
        chk(fs_cnt == 5, "R6 early and late pulses accepted", fs_cnt, 5);
        chk(nval > 6 * nch, "R6 bytes kept flowing", nval, 6 * nch);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule